// File: doc/BRIEF.md
# Receive Ring Buffer Packet Writer

This block stores each accepted Ethernet frame into a circular buffer in local memory. The buffer is built from 256-byte pages. It lies between a programmable first page and an end page, where the end page is one past the last usable page. Frame bytes arrive one per cycle with start, end and abort markers. The block writes them through a byte-wide memory write port. A 4-byte descriptor sits at the front of the frame's first page, and the payload starts at offset 4 of that page.

The descriptor can only be completed once the frame length is known. So after the last byte the block first zero-pads short frames. It then writes the descriptor bytes, leaving the status byte for last. In the same cycle as the status write it moves its current-page pointer to the page after the frame and raises a sticky receive interrupt flag. A frame is refused at its start marker in two cases: the controller is halted, or the free space between the current page and the host's boundary page is too small for one maximum-size frame. The host can load the current-page pointer directly.

Top module: `rxring_writer`

## Requirements
- R1: After a synchronous active-low reset, `mem_we` is 0, `cur_pg` is 0x00 and `irq_rx` is 0.
- R2: A frame with fewer than 60 stored bytes is followed by zero bytes until 60 have been written. One zero is written per cycle, starting the cycle after the last payload write.
- R3: For an accepted frame, byte k of the payload is written to address `cur_pg*256 + 4 + k` (subject to R5). The write appears on the port one cycle after the byte is presented, and a cycle with `rx_valid` low writes nothing.
- R4: The descriptor occupies offsets 0..3 of the frame's first page. Offset 0 holds the status, offset 1 the next page, offset 2 the low byte of the length and offset 3 the high byte of the length. The length is the stored byte count plus 4. The four bytes are written on consecutive cycles in the order offset 3, 2, 1, 0, right after the last payload or pad write.
- R5: When a payload or pad write address would step onto `ring_stop*256`, the next address is `ring_start*256` instead.
- R6: The next page is the frame's page plus (length + 4 + 255) / 256, using integer division. If that result is at or above `ring_stop`, (`ring_stop` − `ring_start`) is subtracted from it.
- R7: A start marker is refused, with no write and no pointer change, while `halted` is 1. It is also refused when the free space is below 1518 bytes. Free space is (bnd − cur)*256 when cur < bnd, and (stop − start)*256 − (cur − bnd)*256 otherwise.
- R8: On the cycle the status byte is written, `cur_pg` takes the next page and `irq_rx` becomes 1. `irq_rx` then holds until `irq_clr`, and a set in the same cycle as a clear wins.
- R9: `rx_abort` during the payload ends the frame. No descriptor is written, `cur_pg` and `irq_rx` are unchanged, and the next start marker is accepted normally.
- R10: Payload bytes beyond the 1514th are not written and not counted, so the stored length never exceeds 1518.
- R11: `cur_ld` loads `cur_ld_pg` into `cur_pg` on the next edge. A commit (R8) on the same edge takes priority.
- R12: The status byte is 0x01, or 0x21 when bit 0 of the first payload byte is 1. No other bits are set.
- R13: While padding or writing the descriptor the block ignores its frame input, including start markers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halted | input | 1 | Controller halted; start markers refused |
| ring_start | input | 8 | First page of the ring |
| ring_stop | input | 8 | Page one past the last ring page |
| ring_bnd | input | 8 | Host boundary page (oldest unread) |
| cur_ld | input | 1 | Load current page from host |
| cur_ld_pg | input | 8 | Page value for `cur_ld` |
| rx_valid | input | 1 | Frame byte present |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_abort | input | 1 | Discard the frame in progress |
| rx_data | input | 8 | Frame byte |
| irq_clr | input | 1 | Clear the receive interrupt flag |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_pg | output | 8 | Current page (where the next frame goes) |
| irq_rx | output | 1 | Receive-complete flag |

## Verification
The assertions assume that the ring bounds stay fixed while a frame is in flight, with `ring_start` below `ring_stop`. They also assume that the current and boundary pages always lie inside the ring, so every write address can be checked against the ring. The stimulus sets the ring once and only moves `cur_pg` and `ring_bnd` between frames, always to pages inside the ring. It also never drives `rx_abort` outside a payload in progress, except in the deliberate ignored cases.

// File: rtl/rxring_pkg.sv
// Package: shared constants and the writer state type.
// Assumes byte-wide memory and 8-bit descriptor fields.
package rxring_pkg;
    localparam int HDR_BYTES    = 4;   // descriptor size in front of payload
    localparam int CRC_BYTES    = 4;   // reserved trailer space for page rounding
    localparam int LEN_W        = 16;  // descriptor length field width
    localparam int STAT_OK_BIT  = 0;   // good-frame bit of the status byte
    localparam int STAT_GRP_BIT = 5;   // group-destination bit of the status byte

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_PAD,
        ST_HDR
    } wr_state_e;
endpackage

// File: rtl/rxring_space_chk.sv
// Module: decides whether the ring has room for one maximum-size frame.
// Assumes cur and bnd lie inside [start, stop); purely combinational.
module rxring_space_chk #(
    parameter int PAGE_W     = 8,
    parameter int OFF_W      = 8,
    parameter int NEED_BYTES = 1518
) (
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [PAGE_W-1:0] bnd_pg,
    input  logic [PAGE_W-1:0] cur_pg,
    output logic              full
);
    localparam int SW = PAGE_W + OFF_W + 2;
    localparam logic signed [SW-1:0] NEED_S = SW'(NEED_BYTES);

    logic signed [SW-1:0] cur_b, bnd_b, start_b, stop_b, avail;

    // Free bytes from the current page up to the boundary page, modulo the ring.
    always_comb begin
        cur_b   = $signed({2'b00, cur_pg,   {OFF_W{1'b0}}});
        bnd_b   = $signed({2'b00, bnd_pg,   {OFF_W{1'b0}}});
        start_b = $signed({2'b00, start_pg, {OFF_W{1'b0}}});
        stop_b  = $signed({2'b00, stop_pg,  {OFF_W{1'b0}}});
        if (cur_pg < bnd_pg)
            avail = bnd_b - cur_b;
        else
            avail = (stop_b - start_b) - (cur_b - bnd_b);
        full = (avail < NEED_S);
    end
endmodule

// File: rtl/rxring_next_pg.sv
// Module: derives the stored length and the page following a frame.
// Assumes frm_pg lies inside the ring; purely combinational.
module rxring_next_pg
    import rxring_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    parameter int CNT_W  = 11
) (
    input  logic [PAGE_W-1:0] frm_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [CNT_W-1:0]  stored_cnt,
    output logic [LEN_W-1:0]  total_len,
    output logic [PAGE_W-1:0] next_pg
);
    localparam int ROUND = CRC_BYTES + (1 << OFF_W) - 1;

    logic [LEN_W:0]  span;
    logic [PAGE_W:0] pg_add, sum, wrapped;

    // Length plus trailer rounded up to whole pages, folded back into the ring.
    always_comb begin
        total_len = LEN_W'(stored_cnt) + LEN_W'(HDR_BYTES);
        span      = {1'b0, total_len} + (LEN_W+1)'(ROUND);
        pg_add    = (PAGE_W+1)'(span >> OFF_W);
        sum       = {1'b0, frm_pg} + pg_add;
        wrapped   = sum - ({1'b0, stop_pg} - {1'b0, start_pg});
        next_pg   = (sum >= {1'b0, stop_pg}) ? wrapped[PAGE_W-1:0] : sum[PAGE_W-1:0];
    end
endmodule

// File: rtl/rxring_addr_step.sv
// Module: advances a ring byte address by one, wrapping at the end page.
// Assumes addr lies inside the ring; purely combinational.
module rxring_addr_step #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic [PAGE_W+OFF_W-1:0] addr,
    input  logic [PAGE_W-1:0]       start_pg,
    input  logic [PAGE_W-1:0]       stop_pg,
    output logic [PAGE_W+OFF_W-1:0] addr_nx
);
    localparam int AW = PAGE_W + OFF_W;

    logic [AW:0] inc;

    // Increment, substituting the ring start when the end address is reached.
    always_comb begin
        inc     = {1'b0, addr} + (AW+1)'(1);
        addr_nx = (inc == {1'b0, stop_pg, {OFF_W{1'b0}}}) ? {start_pg, {OFF_W{1'b0}}}
                                                          : inc[AW-1:0];
    end
endmodule

// File: rtl/rxring_writer.sv
// Module: receive ring writer. Streams payload from offset 4 of the current page,
// pads short frames, writes the descriptor (status last), then commits the new
// current page and raises the receive flag.
// Assumes ring bounds stay fixed during a frame and one input byte per cycle at most.
module rxring_writer
    import rxring_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int OFF_W     = 8,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    halted,
    input  logic [PAGE_W-1:0]       ring_start,
    input  logic [PAGE_W-1:0]       ring_stop,
    input  logic [PAGE_W-1:0]       ring_bnd,
    input  logic                    cur_ld,
    input  logic [PAGE_W-1:0]       cur_ld_pg,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_abort,
    input  logic [7:0]              rx_data,
    input  logic                    irq_clr,
    output logic                    mem_we,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic [PAGE_W-1:0]       cur_pg,
    output logic                    irq_rx
);
    localparam int AW         = PAGE_W + OFF_W;
    localparam int CNT_W      = $clog2(MAX_FRAME + 1);
    localparam int NEED_BYTES = MAX_FRAME + CRC_BYTES;
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_FRAME);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    wr_state_e          st;
    logic [AW-1:0]      wptr;
    logic [PAGE_W-1:0]  frm_pg;
    logic [CNT_W-1:0]   cnt;
    logic               grp;
    logic [1:0]         hidx;

    logic               full;
    logic               accept;
    logic [AW-1:0]      first_addr, step_in, step_nx;
    logic [CNT_W-1:0]   cnt_nx;
    logic [LEN_W-1:0]   total_len;
    logic [PAGE_W-1:0]  next_pg;
    logic [7:0]         status_b, hdr_b;

    rxring_space_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .NEED_BYTES(NEED_BYTES)) u_space (
        .start_pg (ring_start),
        .stop_pg  (ring_stop),
        .bnd_pg   (ring_bnd),
        .cur_pg   (cur_pg),
        .full     (full)
    );

    rxring_next_pg #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_next (
        .frm_pg     (frm_pg),
        .start_pg   (ring_start),
        .stop_pg    (ring_stop),
        .stored_cnt (cnt),
        .total_len  (total_len),
        .next_pg    (next_pg)
    );

    rxring_addr_step #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_step (
        .addr     (step_in),
        .start_pg (ring_start),
        .stop_pg  (ring_stop),
        .addr_nx  (step_nx)
    );

    // Start-marker admission, first payload address and capped byte count.
    always_comb begin
        accept     = (st == ST_IDLE) && rx_valid && rx_sof && !halted && !full;
        first_addr = {cur_pg, OFF_W'(HDR_BYTES)};
        step_in    = (st == ST_IDLE) ? first_addr : wptr;
        cnt_nx     = (cnt < MAX_C) ? cnt + ONE_C : cnt;
    end

    // Descriptor byte selected by the header index (3 down to 0).
    always_comb begin
        status_b = 8'(1 << STAT_OK_BIT) | (grp ? 8'(1 << STAT_GRP_BIT) : 8'h00);
        case (hidx)
            2'd3:    hdr_b = total_len[15:8];
            2'd2:    hdr_b = total_len[7:0];
            2'd1:    hdr_b = 8'(next_pg);
            default: hdr_b = status_b;
        endcase
    end

    // Frame sequencer: payload, padding, descriptor and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            wptr      <= '0;
            frm_pg    <= '0;
            cnt       <= '0;
            grp       <= 1'b0;
            hidx      <= 2'd3;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            cur_pg    <= '0;
            irq_rx    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (cur_ld)  cur_pg <= cur_ld_pg;
            if (irq_clr) irq_rx <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= first_addr;
                        mem_wdata <= rx_data;
                        wptr      <= step_nx;
                        frm_pg    <= cur_pg;
                        cnt       <= ONE_C;
                        grp       <= rx_data[0];
                        hidx      <= 2'd3;
                        if (rx_eof) st <= (ONE_C >= MIN_C) ? ST_HDR : ST_PAD;
                        else        st <= ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (rx_abort) begin
                        st <= ST_IDLE;
                    end else if (rx_valid) begin
                        if (cnt < MAX_C) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= wptr;
                            mem_wdata <= rx_data;
                            wptr      <= step_nx;
                        end
                        cnt <= cnt_nx;
                        if (rx_eof) st <= (cnt_nx >= MIN_C) ? ST_HDR : ST_PAD;
                    end
                end
                ST_PAD: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= wptr;
                    mem_wdata <= 8'h00;
                    wptr      <= step_nx;
                    cnt       <= cnt_nx;
                    if (cnt_nx >= MIN_C) st <= ST_HDR;
                end
                default: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {frm_pg, OFF_W'(hidx)};
                    mem_wdata <= hdr_b;
                    hidx      <= hidx - 2'd1;
                    if (hidx == 2'd0) begin
                        cur_pg <= next_pg;
                        irq_rx <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Padding cycles always emit a zero write.
    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |=> (mem_we && mem_wdata == 8'h00));

    // Descriptor writes land in the first four bytes of the frame's page.
    assert_hdr_place_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HDR) |=> (mem_we && mem_addr[OFF_W-1:2] == '0 &&
                            mem_addr[AW-1:OFF_W] == frm_pg));

    // Every write stays inside the configured ring.
    assert_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= {ring_start, {OFF_W{1'b0}}} &&
                    mem_addr <  {ring_stop,  {OFF_W{1'b0}}}));

    // A refused start marker produces no write.
    assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && rx_valid && rx_sof && (halted || full)) |=> !mem_we);

    // The flag rises only together with the status-byte write.
    assert_flag_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> (mem_we && mem_addr[OFF_W-1:0] == '0));

    // Stored count never passes the maximum frame size.
    assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_C);

    // The current page moves only on a host load or a commit.
    assert_cur_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_pg) |-> ($past(cur_ld) ||
                              (irq_rx && mem_we && mem_addr[OFF_W-1:0] == '0)));

    // Status byte carries only the good and group bits.
    assert_status_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HDR && hidx == 2'd0) |=> (mem_wdata[0] && (mem_wdata & 8'hDE) == 8'h00));
endmodule

// File: tb/rxring_writer_tb.sv
module rxring_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halted = 1'b0;
    logic [7:0]  ring_start = 8'h40, ring_stop = 8'h80, ring_bnd = 8'h40;
    logic        cur_ld = 1'b0;
    logic [7:0]  cur_ld_pg = 8'h00;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_abort = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        irq_clr = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_pg;
    logic        irq_rx;

    always #10 clk = ~clk;

    rxring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .ring_start(ring_start), .ring_stop(ring_stop), .ring_bnd(ring_bnd),
        .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_abort(rx_abort),
        .rx_data(rx_data), .irq_clr(irq_clr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg(cur_pg), .irq_rx(irq_rx)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Reference model state
    int e_we = 0, e_addr = 0, e_data = 0, e_cur = 0, e_irq = 0;
    string e_tag = "R3";
    int m_mode = 0, m_base = 0, m_wp = 0, m_cnt = 0, m_grp = 0, m_next = 0, m_old = 0;
    int m_ib = 0, m_bb = 0, m_avail = 0;
    int q_a[$], q_d[$];
    string q_t[$];
    int mem_img[int];

    function automatic int pat(int first, int i);
        return (first + 7 * i) & 255;
    endfunction

    function automatic int stepa(int a);
        int n = a + 1;
        if (n == ring_stop * 256) n = ring_start * 256;
        return n;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic void mwr(int a, int d, string t);
        e_we = 1; e_addr = a; e_data = d; e_tag = t;
    endfunction

    function automatic void build_tail();
        int tot;
        while (m_cnt < 60) begin
            q_a.push_back(m_wp); q_d.push_back(0); q_t.push_back("R2");
            m_wp = stepa(m_wp); m_cnt++;
        end
        tot = m_cnt + 4;
        m_next = m_base + (tot + 4 + 255) / 256;
        if (m_next >= ring_stop) m_next = m_next - (ring_stop - ring_start);
        q_a.push_back(m_base * 256 + 3); q_d.push_back(tot / 256); q_t.push_back("R4");
        q_a.push_back(m_base * 256 + 2); q_d.push_back(tot % 256); q_t.push_back("R4");
        q_a.push_back(m_base * 256 + 1); q_d.push_back(m_next);   q_t.push_back("R6");
        q_a.push_back(m_base * 256);     q_d.push_back(m_grp ? 8'h21 : 8'h01); q_t.push_back("R12");
        m_mode = 2;
    endfunction

    // Behavioural reference: advanced on every rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_we = 0; e_cur = 0; e_irq = 0; m_mode = 0;
            q_a.delete(); q_d.delete(); q_t.delete();
        end else begin
            m_old = e_cur;
            e_we = 0;
            if (cur_ld) e_cur = cur_ld_pg;
            if (irq_clr) e_irq = 0;
            case (m_mode)
                0: if (rx_valid && rx_sof) begin
                    m_ib = m_old * 256; m_bb = ring_bnd * 256;
                    m_avail = (m_ib < m_bb) ? m_bb - m_ib
                                            : (ring_stop - ring_start) * 256 - (m_ib - m_bb);
                    if (!halted && m_avail >= 1518) begin
                        m_base = m_old;
                        mwr(m_base * 256 + 4, rx_data, "R3");
                        m_wp = stepa(m_base * 256 + 4);
                        m_cnt = 1; m_grp = rx_data[0];
                        if (rx_eof) build_tail(); else m_mode = 1;
                    end
                end
                1: if (rx_abort) m_mode = 0;
                   else if (rx_valid) begin
                       if (m_cnt < 1514) begin
                           mwr(m_wp, rx_data, "R3");
                           m_wp = stepa(m_wp); m_cnt++;
                       end
                       if (rx_eof) build_tail();
                   end
                default: begin
                    mwr(q_a.pop_front(), q_d.pop_front(), q_t.pop_front());
                    if (q_a.size() == 0) begin
                        e_cur = m_next; e_irq = 1; m_mode = 0;
                    end
                end
            endcase
        end
    end

    // Cycle-by-cycle comparison away from the active edge; memory image capture.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (mem_we !== 1'(e_we) || (e_we != 0 && (mem_addr !== 16'(e_addr) ||
                                                   mem_wdata !== 8'(e_data)))) begin
                miscompares++;
                $display("FAIL %s port we=%0d addr=0x%0h data=0x%0h expected we=%0d addr=0x%0h data=0x%0h",
                         e_tag, mem_we, mem_addr, mem_wdata, e_we, e_addr, e_data);
            end
            if (cur_pg !== 8'(e_cur) || irq_rx !== 1'(e_irq)) begin
                miscompares++;
                $display("FAIL R8 cur=0x%0h irq=%0d expected cur=0x%0h irq=%0d",
                         cur_pg, irq_rx, e_cur, e_irq);
            end
            if (mem_we === 1'b1) mem_img[int'(mem_addr)] = int'(mem_wdata);
        end
    end

    task automatic send(int n, int first, bit abrt, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (!abrt && i == n - 1);
            rx_data = 8'(pat(first, i));
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        if (abrt) rx_abort = 1'b1;
        @(negedge clk);
        rx_abort = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    task automatic load_cur(int pg);
        @(negedge clk); cur_ld = 1'b1; cur_ld_pg = 8'(pg);
        @(negedge clk); cur_ld = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    function automatic int img(int a);
        return mem_img.exists(a) ? mem_img[a] : -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 we", int'(mem_we), 0);
        chk("R1 cur", int'(cur_pg), 0);
        chk("R1 irq", int'(irq_rx), 0);
        rst_n = 1'b1;

        load_cur(8'h40);
        chk("R11 load", int'(cur_pg), 8'h40);

        // Short unicast frame: padded, one page
        send(20, 8'h10, 1'b0, 70);
        chk("R6 next after short", int'(cur_pg), 8'h41);
        chk("R8 flag", int'(irq_rx), 1);
        chk("R12 status", img(16'h4000), 8'h01);
        chk("R4 len lo", img(16'h4002), 64);
        chk("R4 len hi", img(16'h4003), 0);
        chk("R2 last pad", img(16'h4000 + 4 + 59), 0);
        clear_irq();
        chk("R8 clear", int'(irq_rx), 0);

        // Group-destination frame spanning two pages
        send(300, 8'h01, 1'b0, 10);
        chk("R6 next 300", int'(cur_pg), 8'h43);
        chk("R12 group status", img(16'h4100), 8'h21);
        chk("R4 len lo 300", img(16'h4102), 304 % 256);
        chk("R4 next byte", img(16'h4101), 8'h43);

        // Back-to-back: second start while descriptor is being written
        send(70, 8'h33, 1'b0, 0);
        send(70, 8'h55, 1'b0, 70);
        chk("R13 second frame ignored", int'(cur_pg), 8'h44);

        // Wrap at the ring end
        ring_bnd = 8'h7E;
        load_cur(8'h7E);
        send(600, 8'h22, 1'b0, 10);
        chk("R5 wrapped byte", img(16'h4000), pat(8'h22, 508));
        chk("R5 last before wrap", img(16'h7FFF), pat(8'h22, 507));
        chk("R6 wrapped next", int'(cur_pg), 8'h41);
        chk("R6 next byte", img(16'h7E01), 8'h41);
        clear_irq();

        // Free space 1024 bytes: refused
        ring_bnd = 8'h45;
        send(60, 8'h44, 1'b0, 10);
        chk("R7 full cur", int'(cur_pg), 8'h41);
        chk("R7 full irq", int'(irq_rx), 0);
        // Free space 1536 bytes: accepted
        ring_bnd = 8'h47;
        send(60, 8'h46, 1'b0, 10);
        chk("R7 room accepted", int'(cur_pg), 8'h42);
        clear_irq();

        // Halted controller
        ring_bnd = 8'h42;
        halted = 1'b1;
        send(60, 8'h48, 1'b0, 10);
        chk("R7 halted cur", int'(cur_pg), 8'h42);
        chk("R7 halted irq", int'(irq_rx), 0);
        halted = 1'b0;

        // Abort in mid-payload, then a normal frame
        send(10, 8'h60, 1'b1, 10);
        chk("R9 abort cur", int'(cur_pg), 8'h42);
        chk("R9 abort irq", int'(irq_rx), 0);
        chk("R9 no status", img(16'h4200) == 8'h01 ? 1 : 0, 0);
        send(64, 8'h62, 1'b0, 10);
        chk("R9 recovery", int'(cur_pg), 8'h43);
        clear_irq();

        // Oversized frame: capped at 1514 stored bytes
        ring_bnd = 8'h43;
        send(1520, 8'h70, 1'b0, 10);
        chk("R10 next", int'(cur_pg), 8'h49);
        chk("R10 len lo", img(16'h4302), 8'hEE);
        chk("R10 len hi", img(16'h4303), 8'h05);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule